// File: doc/BRIEF.md
# Full-Duplex Serial Port with Parity and RTS/CTS Handshake

This block is a full-duplex asynchronous serial port. Its transmitter turns bytes from a valid/ready stream into serial frames on `txd`. Its receiver rebuilds frames from `rxd` and hands them out on a second valid/ready stream. Each received byte comes with its own frame-error, parity-error and overrun flags. One prescale value sets the bit time for both directions: every bit lasts `cfg_prescale + 1` clock cycles.

Hardware flow control uses two active-low lines. When `cfg_flow_en` is set, the transmitter only starts a frame while `cts_n` is low. In the same mode, `rts_n` tells the far end whether the receiver still has room. The receiver holds up to two bytes, so a second frame can arrive while the first one is still unread.

Back-pressure rules. A byte moves on the TX stream only in a cycle where both `tx_valid` and `tx_ready` are high. The source must keep `tx_data` steady until that cycle. On the RX stream, the sink takes a byte by raising `rx_ready` while `rx_valid` is high. Until then, `rx_data` and its flags do not change. The RX stream cannot push back on the serial line. If a frame completes while both RX stages are full, that frame is dropped and the loss is flagged.

Top module: `uart_duplex_flow`

## Requirements
- R1: A frame is sent and received LSB first: one low start bit, 8 data bits, an optional parity bit, then one high stop bit. Each bit lasts `cfg_prescale + 1` clock cycles.
- R2: `cfg_parity` selects the parity bit: 2'b00 means none, 2'b10 means even (the data bits plus the parity bit hold an even number of ones), and 2'b11 means odd. The code 2'b01 behaves as none.
- R3: `tx_ready` is high only while the transmitter is idle and allowed to start, and `txd` is high whenever `tx_ready` is high. In the cycle after a transfer, `tx_ready` is low and `txd` carries the start bit. `tx_ready` is high again in the cycle right after the stop bit ends.
- R4: With `cfg_flow_en` set, no frame starts while `cts_n` is high. Raising `cts_n` during a frame does not change that frame.
- R5: The receiver samples each bit at the middle of its bit time. A low pulse on `rxd` that is no longer low at the middle of the start bit produces no byte.
- R6: `rx_frame_err` is set on a byte whose stop bit was sampled low.
- R7: `rx_parity_err` is set on a byte whose received parity bit does not match the parity mode in force when its start bit was detected.
- R8: Received bytes wait in two stages and come out oldest first. `rx_valid`, `rx_data` and the flags stay unchanged until the byte is taken with `rx_ready`, and taking it moves the next stage forward.
- R9: A frame that completes while both stages are full is discarded, and `rx_overrun` is set on the newer of the two held bytes. Taking that byte clears the flag along with it.
- R10: With `cfg_flow_en` set, `rts_n` is high exactly while both RX stages are full and low otherwise. With `cfg_flow_en` clear, `rts_n` stays low.
- R11: After reset, `txd` is high, `tx_ready` is high (without flow control), `rx_valid` is low and `rts_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_prescale | input | 16 | Bit time minus one, in clock cycles |
| cfg_parity | input | 2 | Parity mode (00 none, 10 even, 11 odd) |
| cfg_flow_en | input | 1 | Enables RTS/CTS handshake |
| tx_valid | input | 1 | TX stream byte valid |
| tx_data | input | 8 | TX stream byte |
| tx_ready | output | 1 | Transmitter accepts a byte |
| txd | output | 1 | Serial output, idles high |
| cts_n | input | 1 | Clear to send, active low |
| rxd | input | 1 | Serial input, idles high |
| rts_n | output | 1 | Request to send, active low |
| rx_valid | output | 1 | RX stream byte valid |
| rx_ready | input | 1 | Sink takes the RX byte |
| rx_data | output | 8 | Received byte |
| rx_frame_err | output | 1 | Stop bit was low for this byte |
| rx_parity_err | output | 1 | Parity mismatch for this byte |
| rx_overrun | output | 1 | A later frame was lost after this byte |

## Verification
All 256 byte values are sent through the transmitter and through the receiver in each of the three parity modes. Because every value is covered, this sweep separates a wrong bit order, a wrong parity sense and an off-by-one in the bit count. A single frame in the unused code 01 shows whether that code really sends no parity bit. Frames are also received with a corrupted parity bit or a low stop bit, and a short low glitch is sent in place of a start bit, to show that each error flag and the start-bit rejection respond only to their own fault. A burst of three unread frames with flow control on covers the overrun drop, the flag landing on the right byte and the RTS level as stages fill and drain. Finally, CTS is held off before a frame and then raised during one, to separate start gating from interruption of a frame already in progress.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int unsigned UART_DW = 8;
  localparam int unsigned UART_PW = 16;

  typedef struct packed {
    logic [UART_DW-1:0] data;
    logic               ferr;
    logic               perr;
    logic               ovr;
  } rx_word_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;
endpackage

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] presc,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          gate_ok,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          txd
);
  localparam int unsigned FW = DW + 3;
  localparam int unsigned IW = $clog2(FW + 1);
  localparam logic [IW-1:0] LAST_PAR   = IW'(DW + 2);
  localparam logic [IW-1:0] LAST_NOPAR = IW'(DW + 1);

  logic          busy;
  logic [PW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [IW-1:0] last;
  logic [FW-1:0] sh;
  logic          pbit;

  assign pbit     = (^in_data) ^ par_odd;
  assign in_ready = !busy && gate_ok;
  assign txd      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      last <= '0;
      sh   <= '1;
    end else if (!busy) begin
      if (in_valid && in_ready) begin
        busy <= 1'b1;
        cnt  <= '0;
        idx  <= '0;
        last <= par_en ? LAST_PAR : LAST_NOPAR;
        sh   <= par_en ? {1'b1, pbit, in_data, 1'b0} : {2'b11, in_data, 1'b0};
      end
    end else if (cnt == presc) begin
      cnt <= '0;
      sh  <= {1'b1, sh[FW-1:1]};
      idx <= idx + 1'b1;
      if (idx == last) busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] presc,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rxd,
  output logic          push,
  output rx_word_t      word
);
  localparam int unsigned IW = $clog2(DW + 2);
  localparam logic [IW-1:0] IDX_DATA_END = IW'(DW);

  rx_state_t     st;
  logic          s1, s2;
  logic [PW-1:0] cnt;
  logic [PW-1:0] half;
  logic [IW-1:0] idx;
  logic [DW-1:0] sh;
  logic          pen, podd, pbit;

  assign half = presc >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      pen  <= 1'b0;
      podd <= 1'b0;
      pbit <= 1'b0;
      push <= 1'b0;
      word <= '0;
    end else begin
      push <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          if (!s2) begin
            st   <= RX_START;
            cnt  <= '0;
            idx  <= '0;
            pen  <= par_en;
            podd <= par_odd;
          end
        end
        RX_START: begin
          if (cnt == half) begin
            cnt <= '0;
            st  <= s2 ? RX_IDLE : RX_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt == presc) begin
            cnt <= '0;
            if (idx < IDX_DATA_END) begin
              sh  <= {s2, sh[DW-1:1]};
              idx <= idx + 1'b1;
            end else if (pen && idx == IDX_DATA_END) begin
              pbit <= s2;
              idx  <= idx + 1'b1;
            end else begin
              push      <= 1'b1;
              word.data <= sh;
              word.ferr <= !s2;
              word.perr <= pen && (pbit != ((^sh) ^ podd));
              word.ovr  <= 1'b0;
              st        <= RX_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_word_t in_word,
  input  logic     pop_req,
  output logic     out_valid,
  output rx_word_t out_word,
  output logic     full
);
  rx_word_t head, back;
  logic     hv, bv, pop;

  assign pop       = pop_req && hv;
  assign out_valid = hv;
  assign out_word  = head;
  assign full      = hv && bv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      back <= '0;
      hv   <= 1'b0;
      bv   <= 1'b0;
    end else if (pop && push) begin
      if (bv) begin
        head <= back;
        back <= in_word;
      end else begin
        head <= in_word;
      end
    end else if (pop) begin
      if (bv) begin
        head <= back;
        bv   <= 1'b0;
      end else begin
        hv <= 1'b0;
      end
    end else if (push) begin
      if (!hv) begin
        head <= in_word;
        hv   <= 1'b1;
      end else if (!bv) begin
        back <= in_word;
        bv   <= 1'b1;
      end else begin
        back.ovr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_duplex_flow.sv
module uart_duplex_flow
  import uart_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [UART_PW-1:0] cfg_prescale,
  input  logic [1:0]         cfg_parity,
  input  logic               cfg_flow_en,
  input  logic               tx_valid,
  input  logic [UART_DW-1:0] tx_data,
  output logic               tx_ready,
  output logic               txd,
  input  logic               cts_n,
  input  logic               rxd,
  output logic               rts_n,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [UART_DW-1:0] rx_data,
  output logic               rx_frame_err,
  output logic               rx_parity_err,
  output logic               rx_overrun
);
  logic     par_en, par_odd, gate_ok, rx_push, buf_full;
  rx_word_t rx_new, rx_head;

  assign par_en  = cfg_parity[1];
  assign par_odd = cfg_parity[0];
  assign gate_ok = !cfg_flow_en || !cts_n;

  uart_tx_engine #(.DW(UART_DW), .PW(UART_PW)) u_tx (
    .clk(clk), .rst_n(rst_n), .presc(cfg_prescale), .par_en(par_en),
    .par_odd(par_odd), .gate_ok(gate_ok), .in_valid(tx_valid),
    .in_data(tx_data), .in_ready(tx_ready), .txd(txd)
  );

  uart_rx_engine #(.DW(UART_DW), .PW(UART_PW)) u_rx (
    .clk(clk), .rst_n(rst_n), .presc(cfg_prescale), .par_en(par_en),
    .par_odd(par_odd), .rxd(rxd), .push(rx_push), .word(rx_new)
  );

  uart_rx_buffer u_buf (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .in_word(rx_new),
    .pop_req(rx_ready), .out_valid(rx_valid), .out_word(rx_head),
    .full(buf_full)
  );

  assign rts_n         = cfg_flow_en && buf_full;
  assign rx_data       = rx_head.data;
  assign rx_frame_err  = rx_head.ferr;
  assign rx_parity_err = rx_head.perr;
  assign rx_overrun    = rx_head.ovr;
endmodule

// File: rtl/uart_duplex_flow_checker.sv
module uart_duplex_flow_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_flow_en,
  input logic       cts_n,
  input logic       rts_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);
  assert_idle_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_ready && !txd));

  assert_cts_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && cfg_flow_en) |-> !cts_n);

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_rts_only_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rts_n |-> (cfg_flow_en && rx_valid));
endmodule

bind uart_duplex_flow uart_duplex_flow_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_flow_en(cfg_flow_en), .cts_n(cts_n),
  .rts_n(rts_n), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/uart_duplex_flow_test.sv
`timescale 1ns/1ps
module uart_duplex_flow_test;
  localparam int PRESC = 3;
  localparam int BITC  = PRESC + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_prescale = 16'(PRESC);
  logic [1:0]  cfg_parity = 2'b00;
  logic        cfg_flow_en = 1'b0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_ready, txd;
  logic        cts_n = 1'b0;
  logic        rxd = 1'b1;
  logic        rts_n, rx_valid;
  logic        rx_ready = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_frame_err, rx_parity_err, rx_overrun;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_duplex_flow uut (
    .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale),
    .cfg_parity(cfg_parity), .cfg_flow_en(cfg_flow_en),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd),
    .cts_n(cts_n), .rxd(rxd), .rts_n(rts_n), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .rx_overrun(rx_overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] frame_bits(input logic [7:0] d, input logic [1:0] m);
    logic p;
    p = (^d) ^ m[0];
    if (m[1]) return {1'b1, p, d, 1'b0};
    return {2'b11, d, 1'b0};
  endfunction

  task automatic tx_frame(input logic [7:0] d, input string req);
    logic [10:0] exp, got;
    int nb;
    nb  = cfg_parity[1] ? 11 : 10;
    exp = frame_bits(d, cfg_parity);
    got = '1;
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      got[i] = txd;
      repeat (BITC - 1) @(negedge clk);
    end
    check(got == exp, req, int'(got), int'(exp));
    check(tx_ready == (!cfg_flow_en || !cts_n), "R3 ready after stop", int'(tx_ready), 1);
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [10:0] f;
    int nb;
    nb = cfg_parity[1] ? 11 : 10;
    f  = frame_bits(d, cfg_parity);
    if (bad_par)  f[9] = ~f[9];
    if (bad_stop) f[nb-1] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rxd = f[i];
      repeat (BITC - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITC) @(negedge clk);
  endtask

  task automatic rx_take;
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] modes [3];
    modes[0] = 2'b00; modes[1] = 2'b10; modes[2] = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(txd == 1'b1, "R11 txd", int'(txd), 1);
    check(tx_ready == 1'b1, "R11 tx_ready", int'(tx_ready), 1);
    check(rx_valid == 1'b0, "R11 rx_valid", int'(rx_valid), 0);
    check(rts_n == 1'b0, "R11 rts_n", int'(rts_n), 0);

    // R1 R2 R3: transmit sweep over every byte and parity mode
    for (int m = 0; m < 3; m++) begin
      cfg_parity = modes[m];
      for (int v = 0; v < 256; v++) tx_frame(8'(v), "R1 R2 tx frame");
    end
    cfg_parity = 2'b01;
    tx_frame(8'hA7, "R2 code 01 sends no parity");

    // R1 R2 R8: receive sweep
    for (int m = 0; m < 3; m++) begin
      cfg_parity = modes[m];
      for (int v = 0; v < 256; v++) begin
        rx_frame(8'(v), 1'b0, 1'b0);
        check(rx_valid && rx_data == 8'(v), "R1 R8 rx data", int'(rx_data), v);
        check({rx_frame_err, rx_parity_err, rx_overrun} == 3'b000, "R2 rx flags clean",
              int'({rx_frame_err, rx_parity_err, rx_overrun}), 0);
        rx_take();
      end
    end
    check(rx_valid == 1'b0, "R8 empty after takes", int'(rx_valid), 0);

    // R7 parity error, even and odd
    cfg_parity = 2'b10;
    rx_frame(8'h5C, 1'b1, 1'b0);
    check(rx_parity_err && !rx_frame_err && rx_data == 8'h5C, "R7 even mismatch",
          int'({rx_parity_err, rx_frame_err}), 2);
    rx_take();
    cfg_parity = 2'b11;
    rx_frame(8'h01, 1'b1, 1'b0);
    check(rx_parity_err == 1'b1, "R7 odd mismatch", int'(rx_parity_err), 1);
    rx_take();

    // R6 frame error
    cfg_parity = 2'b00;
    rx_frame(8'h3E, 1'b0, 1'b1);
    check(rx_frame_err && !rx_parity_err, "R6 low stop bit",
          int'({rx_frame_err, rx_parity_err}), 2);
    rx_take();
    check(rx_valid == 1'b0, "R6 take clears", int'(rx_valid), 0);

    // R5 short start glitch
    @(negedge clk); rxd = 1'b0;
    repeat (2) @(negedge clk); rxd = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    check(rx_valid == 1'b0, "R5 glitch rejected", int'(rx_valid), 0);

    // R9 R10 overrun with flow control
    cfg_flow_en = 1'b1;
    rx_frame(8'h11, 1'b0, 1'b0);
    check(rts_n == 1'b0, "R10 one stage used", int'(rts_n), 0);
    rx_frame(8'h22, 1'b0, 1'b0);
    check(rts_n == 1'b1, "R10 both full", int'(rts_n), 1);
    rx_frame(8'h33, 1'b0, 1'b0);
    check(rx_data == 8'h11 && !rx_overrun, "R9 oldest unflagged",
          int'({rx_overrun, rx_data}), 'h011);
    rx_take();
    check(rts_n == 1'b0, "R10 stage freed", int'(rts_n), 0);
    check(rx_valid && rx_data == 8'h22 && rx_overrun, "R9 newer flagged",
          int'({rx_overrun, rx_data}), 'h122);
    rx_take();
    check(rx_valid == 1'b0, "R9 dropped frame absent", int'(rx_valid), 0);

    // R4 CTS gating
    cts_n = 1'b1;
    @(negedge clk);
    tx_data = 8'hC3; tx_valid = 1'b1;
    begin
      bit held;
      held = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (tx_ready || !txd) held = 1'b0;
      end
      check(held, "R4 no start while cts_n high", int'(held), 1);
    end
    tx_valid = 1'b0;
    cts_n = 1'b0;
    fork
      tx_frame(8'hC3, "R4 frame after cts");
    join
    fork
      tx_frame(8'h96, "R4 frame survives cts deassert");
      begin
        repeat (8) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    cts_n = 1'b0;
    cfg_flow_en = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule